// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Divider

This block turns a reference clock into three timing outputs for a real-time clock: a one-second update pulse, a periodic pulse at a rate chosen by software, and a square-wave pin. It runs directly on the reference clock. A three-bit divider-control field in control register A states which of three reference frequencies is fitted (about 4.19 MHz, 1.05 MHz or 32.768 kHz). The other codes of that field hold the whole divider chain in reset. A four-bit rate code in the same register picks the periodic frequency. Code 0 turns the periodic output off, code 1 selects the highest tap, and code 15 gives 2 Hz.

Control register B supplies two enables. One passes the periodic pulse on as an interrupt request. The other lets the square-wave pin toggle. When software releases the chain from reset, the first one-second pulse arrives half a second later, so the seconds can be set at a known phase. A change of rate code takes effect at the next tap boundary of the running chain without restarting it.

Top module: `rtc_periodic_div`

## Requirements
- R1: The divider-control field is `ctrl_a[6:4]`. Code 2 means a 32.768 kHz reference (scale s=0), code 1 means 1.048576 MHz (s=5), and code 0 means 4.194304 MHz (s=7). The chain counts one step per reference cycle, so the periodic period is 2^(n-1+s) reference cycles for rate code n.
- R2: Divider-control codes 3 to 7 hold the chain. While it is held, `sec_tick`, `per_tick`, `per_irq` and `sqw_out` are low, and the chain restarts from zero on release.
- R3: The rate code is `ctrl_a[3:0]`. For n in 1..15, `per_tick` is a one-cycle pulse every 2^(n-1+s) cycles, and the first pulse comes that many cycles after release. With s=0, code 1 pulses every cycle (32768 Hz) and code 15 pulses every 16384 cycles (2 Hz).
- R4: Rate code 0 produces no `per_tick`, no `per_irq` and no square-wave toggling.
- R5: `per_irq` equals `per_tick` when `ctrl_b[6]` is 1 and stays low when it is 0.
- R6: While `ctrl_b[3]` is 1, `sqw_out` inverts in the same cycle that each `per_tick` pulse appears. While `ctrl_b[3]` is 0, `sqw_out` is low.
- R7: `sec_tick` is a one-cycle pulse. The first one comes 2^(14+s) cycles after release, and the later ones follow every 2^(15+s) cycles.
- R8: A new rate code applies from the next cycle of the running chain, without a restart. `sqw_out` rises only in a cycle that carries `per_tick`.
- R9: After reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the whole block runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_a | input | 8 | Control register A: [6:4] divider control, [3:0] rate code |
| ctrl_b | input | 8 | Control register B: [6] periodic interrupt enable, [3] square-wave enable |
| sec_tick | output | 1 | One-second update pulse |
| per_tick | output | 1 | Periodic pulse at the selected rate |
| per_irq | output | 1 | Periodic pulse gated by the interrupt enable |
| sqw_out | output | 1 | Square-wave output |

## Verification
The hardest case to reach from the ports is the half-second phase of the first update pulse. It is only visible if the bench holds the chain and then counts reference cycles from the exact cycle of release. The bench uses the 32.768 kHz setting for this and measures both the first pulse and the full second after it. For the periodic taps, each table entry first holds the chain and then releases it with a new reference and rate. The bench then measures the first pulse and one full interval, which makes the reference scale and the rate code visible as cycle counts.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  // log2 of reference cycles per second at the slowest reference
  localparam int unsigned SEC_LOG2  = 15;
  // largest extra shift needed for the fastest reference
  localparam int unsigned MAX_SHIFT = 7;
  // half-second counter width at the fastest reference
  localparam int unsigned CNT_W     = SEC_LOG2 - 1 + MAX_SHIFT;
  localparam int unsigned SH_W      = 3;

  typedef enum logic [2:0] {
    REF_FAST = 3'd0,
    REF_MID  = 3'd1,
    REF_SLOW = 3'd2
  } ref_sel_e;

  // low-bit mask of width w inside a CNT_W counter (saturates at all ones)
  function automatic logic [CNT_W-1:0] low_mask(input int unsigned w);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << w;
    return CNT_W'(one_hot - (CNT_W+1)'(1));
  endfunction
endpackage

// File: rtl/rtc_div_refsel.sv
module rtc_div_refsel
  import rtc_div_pkg::*;
(
  input  logic [2:0]      div_ctl,
  output logic            run,
  output logic [SH_W-1:0] shift
);
  always_comb begin
    run   = 1'b1;
    shift = '0;
    case (div_ctl)
      REF_FAST: shift = SH_W'(MAX_SHIFT);
      REF_MID:  shift = SH_W'(5);
      REF_SLOW: shift = '0;
      default:  run   = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SH_W-1:0]  shift,
  output logic [CNT_W-1:0] cnt,
  output logic             sec_tick
);
  logic [CNT_W-1:0] cnt_d;
  logic             phase_q, phase_d;
  logic             sec_d;
  logic             half_hit;

  always_comb begin
    half_hit = (cnt & low_mask(SEC_LOG2 - 1 + int'(shift))) ==
               low_mask(SEC_LOG2 - 1 + int'(shift));
    cnt_d    = cnt;
    phase_d  = phase_q;
    sec_d    = 1'b0;
    if (!run) begin
      cnt_d   = '0;
      phase_d = 1'b1;
    end else begin
      cnt_d = cnt + 1'b1;
      if (half_hit) begin
        phase_d = ~phase_q;
        sec_d   = phase_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_q  <= 1'b1;
      sec_tick <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      phase_q  <= phase_d;
      sec_tick <= sec_d;
    end
  end
endmodule

// File: rtl/rtc_div_tap.sv
module rtc_div_tap
  import rtc_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SH_W-1:0]  shift,
  input  logic [CNT_W-1:0] cnt,
  input  logic [3:0]       rate,
  input  logic             irq_en,
  input  logic             sqw_en,
  output logic             per_tick,
  output logic             per_irq,
  output logic             sqw_out
);
  logic [CNT_W-1:0] mask;
  logic             hit;
  logic             tick_d, irq_d, sqw_d;

  always_comb begin
    mask   = low_mask(int'(rate) - 1 + int'(shift));
    hit    = run && (rate != 4'd0) && ((cnt & mask) == mask);
    tick_d = hit;
    irq_d  = hit && irq_en;
    if (!run || !sqw_en)
      sqw_d = 1'b0;
    else if (hit)
      sqw_d = ~sqw_out;
    else
      sqw_d = sqw_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_tick <= 1'b0;
      per_irq  <= 1'b0;
      sqw_out  <= 1'b0;
    end else begin
      per_tick <= tick_d;
      per_irq  <= irq_d;
      sqw_out  <= sqw_d;
    end
  end
endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div
  import rtc_div_pkg::*;
(
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl_a,
  input  logic [7:0] ctrl_b,
  output logic       sec_tick,
  output logic       per_tick,
  output logic       per_irq,
  output logic       sqw_out
);
  localparam int unsigned DIV_LSB = 4;
  localparam int unsigned PIE_BIT = 6;
  localparam int unsigned SQW_BIT = 3;

  logic             run;
  logic [SH_W-1:0]  shift;
  logic [CNT_W-1:0] cnt;

  rtc_div_refsel refsel_i (
    .div_ctl (ctrl_a[DIV_LSB+2:DIV_LSB]),
    .run     (run),
    .shift   (shift)
  );

  rtc_div_chain chain_i (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .run      (run),
    .shift    (shift),
    .cnt      (cnt),
    .sec_tick (sec_tick)
  );

  rtc_div_tap tap_i (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .run      (run),
    .shift    (shift),
    .cnt      (cnt),
    .rate     (ctrl_a[3:0]),
    .irq_en   (ctrl_b[PIE_BIT]),
    .sqw_en   (ctrl_b[SQW_BIT]),
    .per_tick (per_tick),
    .per_irq  (per_irq),
    .sqw_out  (sqw_out)
  );
endmodule

// File: rtl/rtc_periodic_div_chk.sv
module rtc_periodic_div_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic [7:0] ctrl_a,
  input logic [7:0] ctrl_b,
  input logic       sec_tick,
  input logic       per_tick,
  input logic       per_irq,
  input logic       sqw_out
);
  // R2
  hold_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ctrl_a[6:4] > 3'd2) |=> (!sec_tick && !per_tick && !sqw_out));

  // R4
  rate_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ctrl_a[3:0] == 4'd0) |=> !per_tick);

  // R5
  irq_gate_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    per_irq |-> per_tick);

  // R6
  sqw_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ctrl_b[3] |=> !sqw_out);

  // R8
  sqw_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(sqw_out) |-> per_tick);

  // R7
  sec_single_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
endmodule

bind rtc_periodic_div rtc_periodic_div_chk chk_i (.*);

// File: tb/rtc_periodic_div_tb_top.sv
module rtc_periodic_div_tb_top;
  logic       ref_clk;
  logic       rst_n;
  logic [7:0] ctrl_a;
  logic [7:0] ctrl_b;
  logic       sec_tick, per_tick, per_irq, sqw_out;

  int n_chk;
  int n_fail;

  rtc_periodic_div dut_i (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .ctrl_a  (ctrl_a),
    .ctrl_b  (ctrl_b),
    .sec_tick(sec_tick),
    .per_tick(per_tick),
    .per_irq (per_irq),
    .sqw_out (sqw_out)
  );

  initial ref_clk = 1'b0;
  always #4 ref_clk = ~ref_clk;

  // vectors: divider code, rate code, expected period in cycles
  localparam int NV = 6;
  localparam int V_DIV  [NV] = '{2, 2, 2, 1, 0, 2};
  localparam int V_RATE [NV] = '{1, 3, 6, 3, 4, 15};
  localparam int V_PER  [NV] = '{1, 4, 32, 128, 1024, 16384};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_a(input int div, input int rate);
    ctrl_a = {1'b0, 3'(div), 4'(rate)};
  endtask

  // count reference cycles from a negedge until the chosen output is high
  task automatic wait_out(input int which, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(posedge ref_clk);
      n++;
      @(negedge ref_clk);
      if ((which == 0 && per_tick) || (which == 1 && sec_tick)) return;
    end
  endtask

  task automatic hold_then(input int div, input int rate);
    @(negedge ref_clk);
    set_a(6, rate);
    repeat (3) @(negedge ref_clk);
    set_a(div, rate);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #8_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    int seen;
    bit bad;
    n_chk = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    ctrl_a = 8'h60;
    ctrl_b = 8'h00;
    repeat (3) @(negedge ref_clk);
    // R9: reset state
    check({sec_tick, per_tick, per_irq, sqw_out} == 4'b0, "R9",
          int'({sec_tick, per_tick, per_irq, sqw_out}), 0);
    rst_n = 1'b1;

    // R1 R3: table of reference/rate settings
    for (int i = 0; i < NV; i++) begin
      hold_then(V_DIV[i], V_RATE[i]);
      wait_out(0, 40000, n);
      check(n == V_PER[i], "R3 first", n, V_PER[i]);
      wait_out(0, 40000, n);
      check(n == V_PER[i], "R1 interval", n, V_PER[i]);
    end

    // R2: hold codes silence every output
    ctrl_b = 8'h48;
    for (int c = 3; c < 8; c++) begin
      @(negedge ref_clk);
      set_a(c, 1);
      seen = 0;
      repeat (50) begin
        @(negedge ref_clk);
        if (sec_tick || per_tick || per_irq || sqw_out) seen++;
      end
      check(seen == 0, "R2 hold", seen, 0);
    end

    // R4: rate code 0 gives no periodic pulse
    hold_then(2, 0);
    seen = 0;
    repeat (300) begin
      @(negedge ref_clk);
      if (per_tick || per_irq || sqw_out) seen++;
    end
    check(seen == 0, "R4 rate off", seen, 0);

    // R5: interrupt gating, both enable values
    ctrl_b = 8'h40;
    hold_then(2, 2);
    bad = 0; seen = 0;
    repeat (40) begin
      @(negedge ref_clk);
      if (per_irq != per_tick) bad = 1;
      if (per_irq) seen++;
    end
    check(!bad && seen == 20, "R5 enabled", seen, 20);
    ctrl_b = 8'h00;
    @(negedge ref_clk);
    seen = 0;
    repeat (40) begin
      @(negedge ref_clk);
      if (per_irq) seen++;
    end
    check(seen == 0, "R5 disabled", seen, 0);

    // R6 R8: square wave inverts on each tick, rises only on ticks
    ctrl_b = 8'h08;
    hold_then(2, 2);
    bad = 0;
    begin
      logic prev;
      prev = sqw_out;
      repeat (64) begin
        @(negedge ref_clk);
        if ((sqw_out != prev) != per_tick) bad = 1;
        prev = sqw_out;
      end
    end
    check(!bad, "R6 toggle", int'(bad), 0);
    ctrl_b = 8'h00;
    @(negedge ref_clk);
    @(negedge ref_clk);
    seen = 0;
    repeat (20) begin
      @(negedge ref_clk);
      if (sqw_out) seen++;
    end
    check(seen == 0, "R6 disabled low", seen, 0);

    // R8: rate change applies without restart
    hold_then(2, 5);
    wait_out(0, 100, n);
    set_a(2, 1);
    @(posedge ref_clk);
    @(negedge ref_clk);
    check(per_tick == 1'b1, "R8 rate change", int'(per_tick), 1);

    // R7: first update pulse half a second after release, then each second
    hold_then(2, 0);
    wait_out(1, 40000, n);
    check(n == 16384, "R7 first", n, 16384);
    wait_out(1, 40000, n);
    check(n == 32768, "R7 interval", n, 32768);

    summary();
    $finish;
  end
endmodule